// File: doc/BRIEF.md
# Tape Label and Blank Detector

This block watches a one-bit sliced envelope of the auxiliary track while the transport winds the tape fast. A qualified long stretch of high envelope marks a label. A qualified long stretch of low envelope marks unrecorded tape. Both decisions are counted in auxiliary-block periods, which a single-cycle tick input marks. The thresholds for raising and dropping each flag are the same number of block ticks.

The block also times each label in clock cycles and turns the length into a five-bit speed count and a two-bit range. The tape speed, as a multiple of normal play speed, is 51.2 × 2^range / count. The range steps by itself: it moves up when a label is too short to register and down when a label is long. An invalid flag marks results that must not be trusted.

All outputs are registered and feed a host-readable status word. When search mode is off, the envelope echo and both flags are held low, and the invalid flag is held high.

Top module: `tape_label_detector`

## Requirements
- R1: While reset is asserted, label_o, blank_o, env_o, spd_count and spd_range are 0 and spd_invalid is 1.
- R2: At the first clock edge that samples search_en low, label_o, blank_o and env_o go low, and they stay low while search_en stays low, whatever env_in and blk_tick do.
- R3: In search mode, env_o equals env_in as sampled at the previous clock edge.
- R4: label_o rises one cycle after the clock edge that samples the QUAL_BLOCKS-th (8) blk_tick of an uninterrupted high envelope run. It falls one cycle after the QUAL_BLOCKS-th tick of an uninterrupted low run. A low gap with fewer ticks leaves it set.
- R5: blank_o mirrors R4 with the envelope levels swapped. label_o and blank_o are never high together. A low run that drops label_o raises blank_o in the same cycle.
- R6: A measured run is one that qualified as a label and began with a rising edge seen in search mode. One cycle after env_o falls at its end, spd_count becomes min(floor(L / (BASE_DIV × 2^(3−r))), 31). Here L is the number of cycles env_o was high and r is the range in force. With BASE_DIV = 16, the divisor is 128, 64, 32 or 16 clocks for r = 0, 1, 2, 3.
- R7: A high run that reaches fewer than 8 ticks, or that was already high when search mode was entered, publishes nothing. spd_count, spd_range and spd_invalid keep their values.
- R8: spd_range reports the range used by the measurement. A result of 0 moves the internal range up by one. A result of 17 or more moves it down by one. The range stays within 0..3.
- R9: spd_invalid is 1 after reset and whenever search mode is off. A measurement clears it, unless that measurement changed the range, in which case it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| search_en | input | 1 | Search mode enable |
| env_in | input | 1 | Sliced envelope of the auxiliary track |
| blk_tick | input | 1 | One-cycle pulse per auxiliary block period |
| env_o | output | 1 | Registered envelope echo, low outside search |
| label_o | output | 1 | Label detected |
| blank_o | output | 1 | Unrecorded tape detected |
| spd_count | output | SC_W | Speed count of the last measurement |
| spd_range | output | 2 | Range of the last measurement |
| spd_invalid | output | 1 | Speed result not trustworthy |

## Verification
Two functions can land in the same cycle. A low run that reaches its eighth tick both drops the label flag and raises the blank flag. The bench provokes this after every measured label with a low run of exactly eight ticks, and the scoreboard compares both flags at that one cycle and at the cycle before it. The reverse pairing, label rising while blank drops, is driven at the start of each label run. A property forbids the two flags from being high together.

// File: rtl/tape_label_detector.sv
module tape_label_detector #(
  parameter int QUAL_BLOCKS = 8,
  parameter int SC_W        = 5,
  parameter int BASE_DIV    = 16,
  parameter int DOWN_TH     = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            search_en,
  input  logic            env_in,
  input  logic            blk_tick,
  output logic            env_o,
  output logic            label_o,
  output logic            blank_o,
  output logic [SC_W-1:0] spd_count,
  output logic [1:0]      spd_range,
  output logic            spd_invalid
);
  localparam int QC_W = $clog2(QUAL_BLOCKS + 1);
  localparam int PC_W = $clog2(BASE_DIV * 8 + 1);
  localparam logic [1:0]      RNG_TOP = 2'd3;
  localparam logic [QC_W-1:0] QUAL    = QC_W'(QUAL_BLOCKS);
  localparam logic [QC_W-1:0] QUAL_M1 = QC_W'(QUAL_BLOCKS - 1);
  localparam logic [SC_W-1:0] SC_MAX  = '1;
  localparam logic [SC_W-1:0] SC_DOWN = SC_W'(DOWN_TH);

  logic            env_q, env_d, tick_q, sv_q, sv_d, armed;
  logic [QC_W-1:0] hi_cnt, lo_cnt;
  logic [PC_W-1:0] pre_cnt, pre_nx, period;
  logic [SC_W-1:0] acc, acc_base;
  logic [1:0]      rng;
  logic            rise, fall, hit, done, go_up, go_dn;

  assign env_o    = env_q;
  assign rise     = env_q & ~env_d;
  assign fall     = ~env_q & env_d;
  assign period   = PC_W'(BASE_DIV) << (RNG_TOP - rng);
  assign pre_nx   = rise ? PC_W'(1) : pre_cnt + 1'b1;
  assign acc_base = rise ? '0 : acc;
  assign hit      = (pre_nx == period);
  assign done     = fall & armed & (hi_cnt == QUAL);
  assign go_up    = done && (acc == '0) && (rng != RNG_TOP);
  assign go_dn    = done && (acc >= SC_DOWN) && (rng != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env_q       <= 1'b0;
      env_d       <= 1'b0;
      tick_q      <= 1'b0;
      sv_q        <= 1'b0;
      sv_d        <= 1'b0;
      armed       <= 1'b0;
      hi_cnt      <= '0;
      lo_cnt      <= '0;
      label_o     <= 1'b0;
      blank_o     <= 1'b0;
      pre_cnt     <= '0;
      acc         <= '0;
      rng         <= 2'd0;
      spd_count   <= '0;
      spd_range   <= 2'd0;
      spd_invalid <= 1'b1;
    end else begin
      env_q  <= search_en & env_in;
      tick_q <= search_en & blk_tick;
      sv_q   <= search_en;
      env_d  <= env_q;
      sv_d   <= sv_q;

      if (!search_en || !env_q)             hi_cnt <= '0;
      else if (tick_q && hi_cnt != QUAL)    hi_cnt <= hi_cnt + 1'b1;
      if (!search_en || env_q)              lo_cnt <= '0;
      else if (tick_q && lo_cnt != QUAL)    lo_cnt <= lo_cnt + 1'b1;

      if (!search_en)                                    label_o <= 1'b0;
      else if (env_q && tick_q && hi_cnt == QUAL_M1)     label_o <= 1'b1;
      else if (!env_q && tick_q && lo_cnt == QUAL_M1)    label_o <= 1'b0;

      if (!search_en)                                    blank_o <= 1'b0;
      else if (!env_q && tick_q && lo_cnt == QUAL_M1)    blank_o <= 1'b1;
      else if (env_q && tick_q && hi_cnt == QUAL_M1)     blank_o <= 1'b0;

      if (env_q) begin
        pre_cnt <= hit ? '0 : pre_nx;
        acc     <= (hit && acc_base != SC_MAX) ? acc_base + 1'b1 : acc_base;
      end

      if (!search_en)        armed <= 1'b0;
      else if (rise && sv_d) armed <= 1'b1;

      if (done) begin
        spd_count <= acc;
        spd_range <= rng;
        if (go_up)      rng <= rng + 2'd1;
        else if (go_dn) rng <= rng - 2'd1;
      end

      if (!search_en) spd_invalid <= 1'b1;
      else if (done)  spd_invalid <= go_up | go_dn;
    end
  end
endmodule

// File: rtl/tape_label_detector_chk.sv
module tape_label_detector_chk #(
  parameter int SC_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            search_en,
  input logic            env_in,
  input logic            env_o,
  input logic            label_o,
  input logic            blank_o,
  input logic [SC_W-1:0] spd_count,
  input logic [1:0]      spd_range,
  input logic            spd_invalid,
  input logic [1:0]      rng
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> (!label_o && !blank_o && !env_o));                       // R2
  AST_ENV_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    search_en |=> (env_o == $past(env_in)));                                 // R3
  AST_LABEL_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(label_o) |-> $past(env_o));                                        // R4
  AST_BLANK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_o) |-> !$past(env_o));                                       // R5
  AST_FLAGS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    !(label_o && blank_o));                                                  // R5
  AST_PUBLISH_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (spd_count != $past(spd_count) || spd_range != $past(spd_range))
      |-> (!$past(env_o) && $past(env_o, 2)));                               // R6
  AST_RANGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rng != $past(rng)) |-> ((int'(rng) == int'($past(rng)) + 1) ||
                             (int'(rng) + 1 == int'($past(rng)))));          // R8
  AST_OFF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !search_en |=> spd_invalid);                                             // R9
endmodule

bind tape_label_detector tape_label_detector_chk #(.SC_W(SC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .search_en(search_en), .env_in(env_in),
  .env_o(env_o), .label_o(label_o), .blank_o(blank_o),
  .spd_count(spd_count), .spd_range(spd_range), .spd_invalid(spd_invalid),
  .rng(rng)
);

// File: tb/tb_tape_label_detector.sv
module tb_tape_label_detector;
  localparam int SC_W = 5;
  localparam int BASE = 16;

  logic clk = 1'b0, rst_n = 1'b0, search_en = 1'b0, env_in = 1'b0, blk_tick = 1'b0;
  logic env_o, label_o, blank_o, spd_invalid;
  logic [SC_W-1:0] spd_count;
  logic [1:0] spd_range;

  tape_label_detector #(.QUAL_BLOCKS(8), .SC_W(SC_W), .BASE_DIV(BASE), .DOWN_TH(17)) dut (
    .clk(clk), .rst_n(rst_n), .search_en(search_en), .env_in(env_in), .blk_tick(blk_tick),
    .env_o(env_o), .label_o(label_o), .blank_o(blank_o),
    .spd_count(spd_count), .spd_range(spd_range), .spd_invalid(spd_invalid));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int kind; int val; string tag; } item_t;
  item_t sb[$];
  int errors = 0, checks = 0, last = 0;
  int e_sc = 0, e_rng = 0, e_pub = 0, e_inv = 1;
  bit finished = 1'b0;
  string kname [6] = '{"label", "blank", "env", "count", "range", "invalid"};

  function automatic int observe(int k);
    case (k)
      0: return int'(label_o);
      1: return int'(blank_o);
      2: return int'(env_o);
      3: return int'(spd_count);
      4: return int'(spd_range);
      default: return int'(spd_invalid);
    endcase
  endfunction

  task automatic expect_at(int due, int kind, int val, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: pops scoreboard items as their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (observe(it.kind) != it.val) begin
        errors++;
        $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                 it.tag, kname[it.kind], cyc, observe(it.kind), it.val);
      end
    end
  end

  task automatic drv(input logic e, input logic t, input logic s);
    @(negedge clk);
    env_in = e; blk_tick = t; search_en = s;
    last = cyc + 1;
  endtask

  function automatic int sc_of(int len, int r);
    int v;
    v = len / (BASE << (3 - r));
    return (v > 31) ? 31 : v;
  endfunction

  task automatic push_pub(int due, string tag);
    expect_at(due, 3, e_sc, tag);
    expect_at(due, 4, e_pub, tag);
    expect_at(due, 5, e_inv, tag);
  endtask

  task automatic run_label(int len, int nt, bit meas);
    for (int i = 0; i < len; i++) begin
      drv(1'b1, (i < nt), 1'b1);
      if (i == 0) expect_at(last, 2, 1, "R3");
      if (nt >= 8 && i == 7) begin
        expect_at(last, 0, 0, "R4");
        expect_at(last + 1, 0, 1, "R4");
        expect_at(last + 1, 1, 0, "R5");
      end
    end
    drv(1'b0, 1'b0, 1'b1);
    expect_at(last, 2, 0, "R3");
    if (meas) begin
      int v, nr;
      v = sc_of(len, e_rng);
      nr = e_rng;
      if (v == 0 && e_rng < 3) nr = e_rng + 1;
      else if (v >= 17 && e_rng > 0) nr = e_rng - 1;
      e_sc = v; e_pub = e_rng; e_inv = (nr != e_rng) ? 1 : 0; e_rng = nr;
      expect_at(last + 1, 3, e_sc, "R6");
      expect_at(last + 1, 4, e_pub, "R8");
      expect_at(last + 1, 5, e_inv, "R9");
    end else begin
      if (nt < 8) expect_at(last, 0, 0, "R7");
      push_pub(last + 1, "R7");
    end
  endtask

  task automatic low_run(int n, bit after_label);
    for (int i = 0; i < n; i++) begin
      drv(1'b0, 1'b1, 1'b1);
      if (i == 7) begin
        if (after_label) begin
          expect_at(last, 0, 1, "R4");
          expect_at(last, 1, 0, "R5");
        end
        expect_at(last + 1, 0, 0, "R4");
        expect_at(last + 1, 1, 1, "R5");
      end
    end
  endtask

  initial begin
    repeat (3) drv(1'b0, 1'b0, 1'b0);
    expect_at(last, 0, 0, "R1"); expect_at(last, 1, 0, "R1"); expect_at(last, 2, 0, "R1");
    expect_at(last, 3, 0, "R1"); expect_at(last, 4, 0, "R1"); expect_at(last, 5, 1, "R1");
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) drv(1'b1, 1'b1, 1'b0);
    expect_at(last, 0, 0, "R2"); expect_at(last, 1, 0, "R2");
    expect_at(last, 2, 0, "R2"); expect_at(last, 5, 1, "R9");

    drv(1'b0, 1'b0, 1'b1); drv(1'b0, 1'b0, 1'b1);
    low_run(8, 1'b0);

    run_label(300, 8, 1'b1);  low_run(8, 1'b1);   // r0 -> 2, valid
    run_label(100, 8, 1'b1);  low_run(8, 1'b1);   // r0 -> 0, up
    run_label(200, 8, 1'b1);  low_run(8, 1'b1);   // r1 -> 3
    run_label(50, 8, 1'b1);   low_run(8, 1'b1);   // r1 -> 0, up
    run_label(20, 8, 1'b1);   low_run(8, 1'b1);   // r2 -> 0, up
    run_label(10, 8, 1'b1);   low_run(8, 1'b1);   // r3 -> 0, clamp top
    run_label(272, 8, 1'b1);  low_run(8, 1'b1);   // r3 -> 17, down
    run_label(543, 8, 1'b1);  low_run(8, 1'b1);   // r2 -> 16, stay
    run_label(1280, 8, 1'b1); low_run(8, 1'b1);   // r2 -> sat 31, down
    run_label(1280, 8, 1'b1); low_run(8, 1'b1);   // r1 -> 20, down
    run_label(4224, 8, 1'b1); low_run(8, 1'b1);   // r0 -> sat 31, clamp bottom

    run_label(300, 5, 1'b0);  low_run(8, 1'b0);   // R7 unqualified run

    for (int i = 0; i < 20; i++) begin
      drv(1'b1, (i < 8), 1'b1);
      if (i == 8) expect_at(last, 0, 1, "R4");
    end
    drv(1'b1, 1'b1, 1'b0);
    expect_at(last, 0, 0, "R2"); expect_at(last, 1, 0, "R2");
    expect_at(last, 2, 0, "R2"); expect_at(last, 5, 1, "R9");
    e_inv = 1;
    for (int i = 0; i < 5; i++) drv(1'b1, 1'b1, 1'b0);
    expect_at(last, 0, 0, "R2");
    for (int i = 0; i < 300; i++) begin
      drv(1'b1, (i < 8), 1'b1);
      if (i == 8) expect_at(last, 0, 1, "R4");
    end
    drv(1'b0, 1'b0, 1'b1);
    push_pub(last + 1, "R7");
    low_run(8, 1'b1);
    run_label(300, 8, 1'b1);  low_run(8, 1'b1);   // R9 cleared again

    run_label(300, 8, 1'b1);
    for (int i = 0; i < 3; i++) begin
      drv(1'b0, 1'b1, 1'b1);
      expect_at(last, 0, 1, "R4");
    end
    for (int i = 0; i < 2; i++) begin
      drv(1'b1, 1'b1, 1'b1);
      expect_at(last, 0, 1, "R4");
    end

    repeat (4) drv(1'b1, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    if (sb.size() > 0) begin
      errors += sb.size();
      checks += sb.size();
      $display("FAIL scoreboard: actual %0d pending items expected 0", sb.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule